// File: doc/BRIEF.md
# Serial Transmitter with Port-Controlled Line and Break Abort

This block serialises bytes onto an asynchronous line. While the transmit enable is set, the shift logic drives the line. Each frame is one low start bit, the data bits with the least significant bit first, and high stop bits. Each bit lasts a fixed number of pulses of an oversampling tick. One byte can wait in a holding register while the previous frame is still shifting out.

While the transmit enable is clear, the shift logic has no say over the pin. Two software port bits set it instead: one gives the pin direction (driven or high impedance) and one gives the pin level. Software can hold the line at mark before it turns the transmitter on.

Clearing the enable resets the transmitter in the next cycle, even in the middle of a frame, and throws away any waiting byte. To send a break, software first programs the port level low and then clears the enable. The line then drops to zero in the same cycle and stays there for as long as software wants.

Top module: `uart_brk_tx`

## Requirements
- R1: While `tx_en` is 0, `txd` equals `port_lvl` and `txd_oe` equals `port_drv` in the same cycle, whatever the transmitter was doing.
- R2: While `tx_en` is 1, `txd_oe` is 1, and `txd` is 1 whenever `busy` is 0.
- R3: A frame is a start bit of 0, then DATA_W data bits with bit 0 first, then STOP_BITS stop bits of 1. Each bit is held for OVERSAMPLE pulses of `tick16`, counted from the first pulse after the cycle in which the frame is loaded.
- R4: `busy` rises in the cycle after a write is accepted. It falls on the tick that ends the last stop bit (OVERSAMPLE × (1+DATA_W+STOP_BITS) ticks after the frame starts) when no byte is waiting.
- R5: While a frame is shifting, one further byte is accepted into the holding register. Its start bit follows the previous stop bit with no idle gap.
- R6: A write is accepted only when `wr_valid` and `wr_ready` are both 1. `wr_ready` is 0 while `tx_en` is 0 or the holding register is full. Writes offered while `wr_ready` is 0 are never transmitted.
- R7: Clearing `tx_en` aborts any frame. `busy` is 0 in the next cycle, and a byte that was waiting is discarded and never sent.
- R8: Break: with `tx_en` at 1, programming `port_lvl` to 0 and then clearing `tx_en` drives `txd` to 0 and `txd_oe` to 1 in the same cycle as the clear.
- R9: Setting `tx_en` again starts from idle. `txd` is 1 and no frame begins until a new byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle oversampling tick pulse |
| tx_en | input | 1 | Transmit enable; clearing it aborts and resets the transmitter |
| port_drv | input | 1 | Pin direction used while disabled (1 = driven) |
| port_lvl | input | 1 | Pin level used while disabled |
| wr_valid | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| wr_ready | output | 1 | Holding register can take a byte |
| txd | output | 1 | Serial line level |
| txd_oe | output | 1 | Serial line output enable |
| busy | output | 1 | Frame shifting or byte waiting |

## Verification
The bench builds the block with DATA_W=8, OVERSAMPLE=16 and STOP_BITS=1, which gives a 160-tick frame. A line monitor in the bench samples the middle of each bit, so every bit position and the exact frame length are checked. It runs both with a tick on every cycle and with sparse random ticks, which exercises how the tick counter holds between pulses. Random bytes with random gaps between writes sometimes fill the holding register, which brings back-to-back frames within reach. Directed sequences cover the cases of the enable: an abort in mid-frame with a byte waiting, the break sequence, writes offered while disabled, and a released pin.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
   // bits in one frame: start + data + stop
   function automatic int frame_bits(input int data_w, input int stop_bits);
      return 1 + data_w + stop_bits;
   endfunction
endpackage

// File: rtl/uart_brk_baud.sv
module uart_brk_baud #(
   parameter int OVERSAMPLE = 16,
   localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic bit_end
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   generate
      if ((1 << CNT_W) == OVERSAMPLE) begin : g_pow2
         assign at_end = &cnt_q;
      end else begin : g_cmp
         assign at_end = (cnt_q == CNT_W'(OVERSAMPLE - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (tick)   cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

   assign bit_end = tick && at_end;

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(OVERSAMPLE - 1)); // R3
endmodule

// File: rtl/uart_brk_hold.sv
module uart_brk_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              accept,
   input  logic [DATA_W-1:0] din,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         dout <= '0;
      end else if (flush) begin
         full <= 1'b0;
      end else if (accept) begin
         full <= 1'b1;
         dout <= din;
      end else if (take) begin
         full <= 1'b0;
      end
   end

   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      full && !take && !flush |=> full && $stable(dout)); // R5
   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> !full); // R6
endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift
   import uart_brk_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int STOP_BITS  = 1,
   parameter int OVERSAMPLE = 16,
   localparam int FRAME_W = frame_bits(DATA_W, STOP_BITS),
   localparam int BIDX_W  = $clog2(FRAME_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              pend,
   input  logic [DATA_W-1:0] pend_data,
   output logic              load,
   output logic              active,
   output logic              ser
);
   logic [FRAME_W-1:0] sreg_q;
   logic [BIDX_W-1:0]  bidx_q;
   logic               bit_end, last_end;

   uart_brk_baud #(.OVERSAMPLE(OVERSAMPLE)) u_baud (
      .clk(clk), .rst_n(rst_n), .clr(!active || !enable),
      .tick(tick), .bit_end(bit_end)
   );

   assign last_end = active && bit_end && (bidx_q == BIDX_W'(FRAME_W - 1));
   assign load     = enable && pend && (!active || last_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !enable) begin
         active <= 1'b0;
         sreg_q <= '1;
         bidx_q <= '0;
      end else if (load) begin
         active <= 1'b1;
         sreg_q <= {{STOP_BITS{1'b1}}, pend_data, 1'b0};
         bidx_q <= '0;
      end else if (last_end) begin
         active <= 1'b0;
      end else if (active && bit_end) begin
         sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
         bidx_q <= bidx_q + 1'b1;
      end
   end

   assign ser = active ? sreg_q[0] : 1'b1;

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> !ser); // R3
   AST_BIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bidx_q <= BIDX_W'(FRAME_W - 1)); // R3
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !active); // R7
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16,
   parameter int STOP_BITS  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              tx_en,
   input  logic              port_drv,
   input  logic              port_lvl,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              txd,
   output logic              txd_oe,
   output logic              busy
);
   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_dw
         $error("DATA_W must lie in 5..9");
      end
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("OVERSAMPLE must be at least 2");
      end
      if (STOP_BITS != 1 && STOP_BITS != 2) begin : g_bad_sb
         $error("STOP_BITS must be 1 or 2");
      end
   endgenerate

   logic              hold_full, load, active, ser, accept;
   logic [DATA_W-1:0] hold_data;

   assign wr_ready = tx_en && !hold_full;
   assign accept   = wr_valid && wr_ready;

   uart_brk_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .flush(!tx_en), .accept(accept),
      .din(wr_data), .take(load), .full(hold_full), .dout(hold_data)
   );

   uart_brk_shift #(
      .DATA_W(DATA_W), .STOP_BITS(STOP_BITS), .OVERSAMPLE(OVERSAMPLE)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .enable(tx_en), .tick(tick16),
      .pend(hold_full), .pend_data(hold_data),
      .load(load), .active(active), .ser(ser)
   );

   // pin selection: serial logic while enabled, port bits otherwise
   always_comb begin
      if (tx_en) begin
         txd    = ser;
         txd_oe = 1'b1;
      end else begin
         txd    = port_lvl;
         txd_oe = port_drv;
      end
   end

   assign busy = active || hold_full;

   AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en && !busy |-> txd); // R2
   AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> !busy); // R7
   AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      accept && tx_en |=> busy || !tx_en); // R4
endmodule

// File: tb/uart_brk_tx_test.sv
module uart_brk_tx_test;
   localparam int CLK_P  = 10;
   localparam int DW     = 8;
   localparam int OVS    = 16;
   localparam int SB     = 1;
   localparam int HALF   = OVS / 2;
   localparam int FTICKS = OVS * (1 + DW + SB);

   logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, tx_en = 1'b0;
   logic port_drv = 1'b1, port_lvl = 1'b1, wr_valid = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic wr_ready, txd, txd_oe, busy;

   int n_chk = 0, n_bad = 0;
   bit mon_on = 1'b0;
   bit tick_sparse = 1'b0;
   logic [DW-1:0] exp_q[$];

   uart_brk_tx #(.DATA_W(DW), .OVERSAMPLE(OVS), .STOP_BITS(SB)) uut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en),
      .port_drv(port_drv), .port_lvl(port_lvl), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_ready(wr_ready), .txd(txd),
      .txd_oe(txd_oe), .busy(busy)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
      end
   endtask

   function automatic int mid_index(input int t);
      return (t - HALF) / OVS;
   endfunction

   // tick generator
   always @(posedge clk) begin
      #1;
      tick16 = tick_sparse ? ($urandom_range(0, 3) == 0) : 1'b1;
   end

   // line monitor
   logic          m_tk, m_acc, m_act = 1'b0;
   logic [DW-1:0] m_wd, m_byte;
   int            m_ticks = 0;
   always @(posedge clk) begin
      m_tk  = tick16;
      m_acc = wr_valid && wr_ready;
      m_wd  = wr_data;
      @(negedge clk);
      if (mon_on) begin
         if (m_acc) exp_q.push_back(m_wd);
         if (!tx_en) begin
            m_act = 1'b0;
            exp_q.delete();
            chk(txd == port_lvl && txd_oe == port_drv, "R1", int'(txd), int'(port_lvl));
         end else begin
            if (!txd_oe) chk(1'b0, "R2", 0, 1);
            if (m_act && m_tk) begin
               m_ticks++;
               if (m_ticks == HALF)
                  chk(txd == 1'b0, "R3 start", int'(txd), 0);
               else if (m_ticks > HALF && (m_ticks - HALF) % OVS == 0 && mid_index(m_ticks) <= DW)
                  m_byte[mid_index(m_ticks) - 1] = txd;
               else if (m_ticks == HALF + OVS * (1 + DW))
                  chk(txd == 1'b1, "R3 stop", int'(txd), 1);
               else if (m_ticks == FTICKS) begin
                  if (exp_q.size() == 0) chk(1'b0, "R3 no byte expected", int'(m_byte), -1);
                  else begin
                     logic [DW-1:0] e;
                     e = exp_q.pop_front();
                     chk(m_byte == e, "R3 data", int'(m_byte), int'(e));
                  end
                  chk(busy == (exp_q.size() > 0), "R4 busy at frame end", int'(busy), int'(exp_q.size() > 0));
                  if (exp_q.size() > 0) chk(txd == 1'b0, "R5 back-to-back", int'(txd), 0);
                  m_act = 1'b0;
               end
            end
            if (!m_act && txd == 1'b0) begin
               if (exp_q.size() == 0) chk(1'b0, "R9/R6 unexpected frame", 0, 1);
               m_act   = 1'b1;
               m_ticks = 0;
            end
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #2;
   endtask

   task automatic write_byte(input logic [DW-1:0] b);
      @(posedge clk); #2;
      while (!wr_ready) begin @(posedge clk); #2; end
      wr_valid = 1'b1; wr_data = b;
      @(posedge clk); #2;
      wr_valid = 1'b0;
      chk(busy == 1'b1, "R4 busy after write", int'(busy), 1);
   endtask

   task automatic drain();
      int guard = 0;
      while ((exp_q.size() > 0 || busy || m_act) && guard < 20000) begin
         @(posedge clk); guard++;
      end
      #2;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #(CLK_P*3) rst_n = 1'b1;
      #2;
      chk(txd == 1'b1 && txd_oe == 1'b1 && busy == 1'b0, "R1 reset", int'({txd, txd_oe, busy}), 6);
      chk(wr_ready == 1'b0, "R6 ready while disabled", int'(wr_ready), 0);
      mon_on = 1'b1;

      // R1: released pin and driven low while disabled
      port_drv = 1'b0; idle(3);
      chk(txd_oe == 1'b0, "R1 released", int'(txd_oe), 0);
      port_drv = 1'b1; port_lvl = 1'b0; idle(3);
      port_lvl = 1'b1; idle(2);

      // R6: writes while disabled are dropped
      for (int i = 0; i < 4; i++) begin
         wr_valid = 1'b1; wr_data = DW'(8'hA5 + i);
         @(posedge clk); #2;
      end
      wr_valid = 1'b0;
      tx_en = 1'b1; #1;
      chk(txd == 1'b1 && busy == 1'b0, "R9 idle on enable", int'(txd), 1);
      idle(300);

      // directed frames, tick every cycle
      write_byte(8'h00); drain();
      write_byte(8'hFF); drain();
      write_byte(8'h01); write_byte(8'h80); drain(); // R5 back-to-back

      // random frames, sparse ticks
      tick_sparse = 1'b1;
      for (int i = 0; i < 24; i++) begin
         write_byte(DW'($urandom));
         if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 900));
      end
      drain();
      tick_sparse = 1'b0;

      // R7: abort mid-frame with a byte waiting
      write_byte(8'h3C); write_byte(8'hC3);
      idle(40);
      tx_en = 1'b0;
      @(posedge clk); #2;
      chk(busy == 1'b0, "R7 busy cleared", int'(busy), 0);
      idle(5);
      tx_en = 1'b1; #1;
      chk(txd == 1'b1, "R9 idle after abort", int'(txd), 1);
      idle(400); // monitor flags any stale frame

      // R8: break sequence
      write_byte(8'h55);
      idle(50);
      port_lvl = 1'b0; #1;
      chk(txd_oe == 1'b1, "R2 oe while enabled", int'(txd_oe), 1);
      tx_en = 1'b0; #1;
      chk(txd == 1'b0 && txd_oe == 1'b1, "R8 break", int'(txd), 0);
      @(posedge clk); #2;
      chk(busy == 1'b0, "R7 busy after break", int'(busy), 0);
      idle(200);
      port_lvl = 1'b1; #1;
      tx_en = 1'b1; #1;
      chk(txd == 1'b1, "R9 mark after break", int'(txd), 1);
      idle(300);
      write_byte(8'h96); drain();

      mon_on = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P*150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule